// File: doc/BRIEF.md
# Dual-Select Asynchronous Write Controller

This block connects an asynchronous SRAM-style host bus to two targets: a small bank of byte-wide timekeeping registers held inside the block, and an external SRAM. The four active-low host strobes are sampled on a fast local clock through a synchronizer, together with the address and the write data. These strobes are chip select, external select, write strobe and output enable.

A write window is open while the write strobe and one select are both low. It opens when the later of the two falls and closes when the earlier of the two rises. The block commits one write when the window closes. An internal register receives it when chip select was low. When only the external select was low, the write leaves on a one-cycle valid pulse toward the SRAM. Reads drive the output bus from the register bank, or forward the SRAM's read data. Two sticky flags are raised for host errors. One marks a select conflict, where both selects are low at once. The other marks protocol misuse, meaning the address moved inside a window or the recovery time was cut short.

Top module: `dsw_wr_ctrl`

## Requirements
- R1: After reset, dq_oe, ext_wr_valid, conflict_err and proto_err are 0, and every internal register reads back 0.
- R2: With chip select low, a write is committed once both strobes have been low and the first of them rises, regardless of which strobe fell first. The data written is the last value of din sampled before the window closed.
- R3: The internal register is chosen by the low log2(NREG) address bits, and the higher address bits play no part in the selection.
- R4: When the external select is low with chip select high, the window's end gives exactly one ext_wr_valid pulse. That pulse carries the window's address on ext_addr and its data on ext_wdata, and no internal register changes.
- R5: dq_oe is 1 only while the write strobe is high, output enable is low and exactly one select is low. dq_out carries the addressed register when chip select is low, and ext_rdata when only the external select is low.
- R6: A falling write strobe during a read drives dq_oe to 0 while the strobe stays low.
- R7: Both selects low at once sets conflict_err, which then stays at 1 until reset. Any write window that overlaps the conflict is dropped for both targets, and dq_oe stays 0 while the conflict lasts.
- R8: If the address changes inside an open window, proto_err is set and stays set. The write still goes to the address sampled when the window opened.
- R9: If a window opens after fewer than REC_CYC sampled cycles with no window, proto_err is set. Windows spaced further apart than that leave it at 0.
- R10: ext_wr_valid is a single-cycle pulse that has no ready signal, so the external target must accept every pulse and no back-pressure is possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select for the internal registers, active low, asynchronous |
| xe_n | input | 1 | External SRAM select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | AW | Host address |
| din | input | DW | Host write data |
| dq_out | output | DW | Read data toward the host |
| dq_oe | output | 1 | Tri-state enable for dq_out |
| ext_wr_valid | output | 1 | One-cycle write pulse to the external SRAM |
| ext_addr | output | AW | External write address |
| ext_wdata | output | DW | External write data |
| ext_rdata | input | DW | Read data from the external SRAM |
| conflict_err | output | 1 | Sticky select-conflict flag |
| proto_err | output | 1 | Sticky address-change or recovery-violation flag |

## Verification
The bench builds the block with NREG=16, AW=6 and REC_CYC=4. With AW=6 the two address bits above the register index can take every value, so the aliasing sweep writes all sixteen registers through varied high bits and in both strobe orderings. It then reads the whole bank back against values it computes arithmetically. REC_CYC=4 places the idle gap of back-to-back host cycles just below the limit and the bench's normal spacing well above it, so both sides of the recovery rule are tested.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_INT  = 2'd1,
    TGT_EXT  = 2'd2
  } tgt_e;
endpackage

// File: rtl/dsw_sync.sv
module dsw_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsw_regfile.sv
module dsw_regfile #(
  parameter int NREG = 16,
  parameter int DW = 8,
  localparam int RA = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RA-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [RA-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dsw_window.sv
module dsw_window
  import dsw_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int REC_CYC = 2,
  localparam int CW = $clog2(REC_CYC + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tgt_e          cur,
  input  logic          conflict,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          commit_ok,
  output tgt_e          commit_tgt,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  output logic          conflict_err,
  output logic          proto_err
);
  tgt_e          win_q;
  logic          abort_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] idle_cnt;
  logic          ending, starting;

  assign ending   = (win_q != TGT_NONE) && (cur != win_q);
  assign starting = (cur != TGT_NONE) && (cur != win_q);

  assign commit_ok   = ending && !abort_q && !conflict;
  assign commit_tgt  = win_q;
  assign commit_addr = addr_q;
  assign commit_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q        <= TGT_NONE;
      abort_q      <= 1'b0;
      addr_q       <= '0;
      data_q       <= '0;
      idle_cnt     <= CW'(REC_CYC);
      conflict_err <= 1'b0;
      proto_err    <= 1'b0;
    end else begin
      win_q <= cur;
      if (starting) begin
        addr_q  <= addr;
        data_q  <= data;
        abort_q <= conflict;
        if (idle_cnt < CW'(REC_CYC)) proto_err <= 1'b1;
      end else if (cur != TGT_NONE) begin
        data_q  <= data;
        abort_q <= abort_q | conflict;
        if (addr != addr_q) proto_err <= 1'b1;
      end
      if (cur == TGT_NONE) begin
        if (idle_cnt < CW'(REC_CYC)) idle_cnt <= idle_cnt + 1'b1;
      end else begin
        idle_cnt <= '0;
      end
      if (conflict) conflict_err <= 1'b1;
    end
  end
endmodule

// File: rtl/dsw_wr_ctrl.sv
module dsw_wr_ctrl
  import dsw_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NREG = 16,
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          xe_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          ext_wr_valid,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata,
  output logic          conflict_err,
  output logic          proto_err
);
  localparam int RA = $clog2(NREG);
  localparam int SW = 4 + AW + DW;
  localparam logic [SW-1:0] SINIT = {4'hF, {(AW + DW){1'b0}}};

  logic          s_ce, s_xe, s_we, s_oe;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_din;
  logic          sel_int, sel_ext, conflict;
  tgt_e          cur;
  logic          commit_ok;
  tgt_e          commit_tgt;
  logic [AW-1:0] commit_addr;
  logic [DW-1:0] commit_data;
  logic [DW-1:0] rf_rdata;
  logic          rf_we;

  dsw_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT(SINIT)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ce_n, xe_n, we_n, oe_n, addr, din}),
    .q    ({s_ce, s_xe, s_we, s_oe, s_addr, s_din})
  );

  assign sel_int  = !s_ce;
  assign sel_ext  = s_ce && !s_xe;
  assign conflict = !s_ce && !s_xe;

  always_comb begin
    cur = TGT_NONE;
    if (!s_we) begin
      if (sel_int)      cur = TGT_INT;
      else if (sel_ext) cur = TGT_EXT;
    end
  end

  dsw_window #(.AW(AW), .DW(DW), .REC_CYC(REC_CYC)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur         (cur),
    .conflict    (conflict),
    .addr        (s_addr),
    .data        (s_din),
    .commit_ok   (commit_ok),
    .commit_tgt  (commit_tgt),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .conflict_err(conflict_err),
    .proto_err   (proto_err)
  );

  assign rf_we = commit_ok && (commit_tgt == TGT_INT);

  dsw_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (rf_we),
    .wr_idx (commit_addr[RA-1:0]),
    .wr_data(commit_data),
    .rd_idx (s_addr[RA-1:0]),
    .rd_data(rf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_wr_valid <= 1'b0;
      ext_addr     <= '0;
      ext_wdata    <= '0;
    end else begin
      ext_wr_valid <= commit_ok && (commit_tgt == TGT_EXT);
      if (commit_ok && (commit_tgt == TGT_EXT)) begin
        ext_addr  <= commit_addr;
        ext_wdata <= commit_data;
      end
    end
  end

  assign dq_oe  = s_we && !s_oe && (sel_int || sel_ext) && !conflict;
  assign dq_out = sel_int ? rf_rdata : ext_rdata;
endmodule

// File: rtl/dsw_wr_ctrl_chk.sv
module dsw_wr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic s_ce,
  input logic s_xe,
  input logic s_we,
  input logic dq_oe,
  input logic ext_wr_valid,
  input logic conflict_err,
  input logic proto_err
);
  // R7
  conflict_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_err |=> conflict_err);

  // R8
  proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R7
  no_ext_on_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ce && !s_xe) |=> !ext_wr_valid);

  // R7
  no_drive_on_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ce && !s_xe) |-> !dq_oe);

  // R6
  no_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_we |-> !dq_oe);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_valid |=> !ext_wr_valid);
endmodule

bind dsw_wr_ctrl dsw_wr_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_ce        (s_ce),
  .s_xe        (s_xe),
  .s_we        (s_we),
  .dq_oe       (dq_oe),
  .ext_wr_valid(ext_wr_valid),
  .conflict_err(conflict_err),
  .proto_err   (proto_err)
);

// File: tb/test_dsw_wr_ctrl.sv
`timescale 1ns/1ps
module test_dsw_wr_ctrl;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NREG = 16;
  localparam int REC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, xe_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] ext_rdata = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, ext_wr_valid, conflict_err, proto_err;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata;

  int checks = 0;
  int errors = 0;
  int ext_cnt = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NREG];

  always #2 clk = ~clk;

  dsw_wr_ctrl #(.AW(AW), .DW(DW), .NREG(NREG), .SYNC_STAGES(2), .REC_CYC(REC)) i_dsw_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .xe_n(xe_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
    .ext_wr_valid(ext_wr_valid), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .conflict_err(conflict_err), .proto_err(proto_err)
  );

  always @(posedge clk) if (rst_n && ext_wr_valid) ext_cnt <= ext_cnt + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1; xe_n = 1; we_n = 1; oe_n = 1;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_sel(input bit ext, input logic v);
    if (ext) xe_n = v; else ce_n = v;
  endtask

  task automatic wr(input bit ext, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit we_first, input int gap);
    @(negedge clk);
    addr = a; din = d;
    if (!we_first) begin set_sel(ext, 0); @(negedge clk); we_n = 0; end
    else begin we_n = 0; @(negedge clk); set_sel(ext, 0); end
    repeat (4) @(negedge clk);
    if (!we_first) begin we_n = 1; @(negedge clk); set_sel(ext, 1); end
    else begin set_sel(ext, 1); @(negedge clk); we_n = 1; end
    repeat (gap) @(negedge clk);
  endtask

  task automatic rd(input bit ext, input logic [AW-1:0] a,
                    output logic [DW-1:0] q, output logic oe);
    @(negedge clk);
    addr = a; set_sel(ext, 0); oe_n = 0;
    repeat (4) @(negedge clk);
    q = dq_out; oe = dq_oe;
    oe_n = 1; set_sel(ext, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q;
    logic oe;
    int base;

    do_reset();
    // R1 reset state
    check("R1 dq_oe", dq_oe, 0);
    check("R1 ext_wr_valid", ext_wr_valid, 0);
    check("R1 conflict_err", conflict_err, 0);
    check("R1 proto_err", proto_err, 0);
    for (int i = 0; i < NREG; i++) begin
      rd(0, AW'(i), q, oe);
      check("R1 reg zero", q, 0);
    end

    // R2, R3: every register, both orderings, varied upper address bits
    for (int i = 0; i < NREG; i++) begin
      logic [DW-1:0] d;
      d = DW'((i * 37 + 5) % 256);
      wr(0, AW'(i + 16 * (i % 4)), d, bit'(i % 2), 8);
      model[i] = d;
    end
    for (int i = 0; i < NREG; i++) begin
      rd(0, AW'(i + 16 * ((i + 1) % 4)), q, oe);
      check("R2 readback", q, model[i]);
      check("R3 alias drive", oe, 1);
    end
    check("R4 no ext pulse on internal writes", ext_cnt, 0);

    // R2: last sampled data in window wins
    @(negedge clk);
    addr = 7; din = 8'h11; ce_n = 0;
    @(negedge clk); we_n = 0;
    repeat (3) @(negedge clk); din = 8'hC3;
    repeat (3) @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    repeat (8) @(negedge clk);
    model[7] = 8'hC3;
    rd(0, 7, q, oe);
    check("R2 late data", q, 8'hC3);

    // R4, R10: external writes
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'((k * 9) % 64);
      d = DW'((k * 29 + 3) % 256);
      base = ext_cnt;
      wr(1, a, d, bit'(k % 2), 8);
      check("R10 one pulse", ext_cnt - base, 1);
      check("R4 ext_addr", ext_addr, a);
      check("R4 ext_wdata", ext_wdata, d);
    end
    for (int i = 0; i < NREG; i++) begin
      rd(0, AW'(i), q, oe);
      check("R4 internal untouched", q, model[i]);
    end

    // R5: read drive rules
    ext_rdata = 8'h5A;
    rd(1, 9, q, oe);
    check("R5 ext read oe", oe, 1);
    check("R5 ext read data", q, 8'h5A);
    @(negedge clk); ce_n = 0; addr = 3;
    repeat (4) @(negedge clk);
    check("R5 no drive without oe", dq_oe, 0);
    ce_n = 1;
    repeat (4) @(negedge clk);

    // R6: falling write strobe during read
    @(negedge clk); addr = 5; din = model[5]; ce_n = 0; oe_n = 0;
    repeat (4) @(negedge clk);
    check("R6 driving before", dq_oe, 1);
    we_n = 0;
    repeat (3) @(negedge clk);
    check("R6 off while write low", dq_oe, 0);
    we_n = 1;
    @(negedge clk); ce_n = 1; oe_n = 1;
    repeat (8) @(negedge clk);

    // R9: spaced windows keep proto_err clear
    check("R9 no false violation", proto_err, 0);
    check("R7 no false conflict", conflict_err, 0);

    // R9: short recovery
    wr(0, 1, 8'h77, 0, 0);
    wr(0, 2, 8'h88, 1, 8);
    check("R9 short recovery flagged", proto_err, 1);
    rd(0, 1, q, oe);
    check("R9 first write kept", q, 8'h77);
    rd(0, 2, q, oe);
    check("R9 second write kept", q, 8'h88);

    // R7: select conflict
    do_reset();
    base = ext_cnt;
    @(negedge clk); addr = 4; din = 8'hEE; ce_n = 0; xe_n = 0;
    @(negedge clk); we_n = 0;
    repeat (4) @(negedge clk); we_n = 1;
    @(negedge clk); oe_n = 0;
    repeat (4) @(negedge clk);
    check("R7 tri-stated during conflict", dq_oe, 0);
    check("R7 flag set", conflict_err, 1);
    ce_n = 1; xe_n = 1; oe_n = 1;
    repeat (8) @(negedge clk);
    check("R7 flag sticky", conflict_err, 1);
    check("R7 no ext write", ext_cnt - base, 0);
    rd(0, 4, q, oe);
    check("R7 no internal write", q, 0);

    // R8: address change inside window
    do_reset();
    @(negedge clk); addr = 3; din = 8'h3C; ce_n = 0;
    @(negedge clk); we_n = 0;
    repeat (3) @(negedge clk); addr = 4;
    repeat (3) @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    repeat (8) @(negedge clk);
    check("R8 flag set", proto_err, 1);
    rd(0, 3, q, oe);
    check("R8 write at start address", q, 8'h3C);
    rd(0, 4, q, oe);
    check("R8 later address untouched", q, 0);
    check("R8 flag sticky", proto_err, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule